// File: doc/BRIEF.md
# Soft-Reset and Clock-Gate Sequencer

This block owns a small control word that lets software put one downstream module through a clean reset-and-park cycle. The word has two live fields: a soft-reset request and a clock-gate flag. Software can reach the word through three write ports on the same register. The plain port loads the whole word. The set port turns on only the fields written with a one. The clear port turns off only the fields written with a one. The current word can always be read back.

When software raises the soft-reset request, the block drives its downstream reset output low straight away. It keeps that reset asserted for a fixed number of cycles and then sets the clock-gate flag on its own, which drops the downstream clock enable. Software polls for the gate flag as its handshake. It then lowers the soft-reset request, waits as long as it needs, and clears the gate to let the downstream module run again. While soft reset is held, software cannot clear the gate, so the downstream clock stays parked until reset has been released.

Top module: `softrst_gate_ctl`

## Requirements
- R1: After a hardware reset, the control word reads all zeros, the downstream reset output is high (not asserted) and the clock enable is high.
- R2: A write with selector 0 (plain) loads the soft-reset field from wr_data bit SRST_POS and the gate field from wr_data bit GATE_POS, subject to R9. Every other bit of the control word always reads zero.
- R3: A write with selector 1 (set) turns on each field whose wr_data bit is one and leaves the other field unchanged.
- R4: A write with selector 2 (clear) turns off each field whose wr_data bit is one and leaves the other field unchanged, subject to R9.
- R5: A write with selector 3 changes nothing.
- R6: The downstream reset output is low exactly while the soft-reset field reads one.
- R7: If the gate field is zero when the soft-reset field becomes one, the hardware sets the gate field exactly HOLD_CYCLES clock cycles later (default 4), provided soft reset is still set.
- R8: The clock-enable output is low exactly while the gate field reads one.
- R9: A write that would turn off the gate field has no effect if the soft-reset field reads one in the cycle of the write.
- R10: Clearing soft reset and then clearing the gate returns the block to the ungated state: the gate reads zero and the clock enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write port: 0 plain, 1 set, 2 clear, 3 reserved |
| wr_data | input | DATA_W | Write data |
| ctrl_rd | output | DATA_W | Current control word |
| blk_rst_n | output | 1 | Active-low reset to the downstream module |
| blk_clk_en | output | 1 | Clock enable to the downstream module |

## Verification
The bench builds the block with an 8-bit word, soft reset at bit 7, gate at bit 6 and a hold of 3 cycles. It sweeps every 8-bit write value through every selector from each of the four field states, including the short window where soft reset is set and the gate has not yet been set. The short hold keeps that window reachable, and it makes exact-cycle timing checks of the automatic gate cheap. The narrow word means every data bit outside the two fields is also covered by the sweep.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  typedef enum logic [1:0] {
    SEL_PLAIN = 2'd0,
    SEL_SET   = 2'd1,
    SEL_CLR   = 2'd2,
    SEL_RSVD  = 2'd3
  } wsel_e;
endpackage

// File: rtl/sgc_rst_sync.sv
module sgc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sgc_alias_decode.sv
module sgc_alias_decode
  import sgc_pkg::*;
#(
  parameter int NF = 2
) (
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [NF-1:0] wr_bits,
  input  logic [NF-1:0] cur,
  output logic [NF-1:0] sw_val,
  output logic          wr_hit
);
  wsel_e sel;
  assign sel = wsel_e'(wr_sel);

  always_comb begin
    wr_hit = wr_en && (sel != SEL_RSVD);
  end

  for (genvar i = 0; i < NF; i++) begin : g_field
    always_comb begin
      sw_val[i] = cur[i];
      if (wr_en) begin
        unique case (sel)
          SEL_PLAIN: sw_val[i] = wr_bits[i];
          SEL_SET:   sw_val[i] = cur[i] | wr_bits[i];
          SEL_CLR:   sw_val[i] = cur[i] & ~wr_bits[i];
          default:   sw_val[i] = cur[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/sgc_hold_seq.sv
module sgc_hold_seq #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_q,
  output logic hw_gate_set
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(HOLD_CYCLES);
  localparam logic [CW-1:0] CNT_FIRE = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          cnt_en;

  always_comb begin
    if (!srst_q)              cnt_nxt = '0;
    else if (cnt_q != CNT_MAX) cnt_nxt = cnt_q + 1'b1;
    else                      cnt_nxt = cnt_q;
    cnt_en      = (cnt_nxt != cnt_q);
    hw_gate_set = srst_q && (cnt_q == CNT_FIRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/softrst_gate_ctl.sv
module softrst_gate_ctl #(
  parameter int DATA_W      = 32,
  parameter int SRST_POS    = 31,
  parameter int GATE_POS    = 30,
  parameter int HOLD_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic              blk_rst_n,
  output logic              blk_clk_en
);
  localparam int NF    = 2;
  localparam int F_SRST = 1;
  localparam int F_GATE = 0;

  logic rst_int_n;
  logic srst_q, gate_q;
  logic srst_nxt, gate_nxt;
  logic reg_en;
  logic hw_gate_set;
  logic wr_hit;
  logic [NF-1:0] wr_bits, cur, sw_val;
  logic unused_wr_bits;

  sgc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign wr_bits        = {wr_data[SRST_POS], wr_data[GATE_POS]};
  assign cur            = {srst_q, gate_q};
  assign unused_wr_bits = ^wr_data;

  sgc_alias_decode #(.NF(NF)) u_dec (
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_bits (wr_bits),
    .cur     (cur),
    .sw_val  (sw_val),
    .wr_hit  (wr_hit)
  );

  sgc_hold_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .srst_q      (srst_q),
    .hw_gate_set (hw_gate_set)
  );

  always_comb begin
    srst_nxt = sw_val[F_SRST];
    if (srst_q) gate_nxt = gate_q | sw_val[F_GATE] | hw_gate_set;
    else        gate_nxt = sw_val[F_GATE] | hw_gate_set;
    reg_en = wr_hit | hw_gate_set;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      srst_q <= 1'b0;
      gate_q <= 1'b0;
    end else if (reg_en) begin
      srst_q <= srst_nxt;
      gate_q <= gate_nxt;
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[SRST_POS] = srst_q;
    ctrl_rd[GATE_POS] = gate_q;
    blk_rst_n         = ~srst_q;
    blk_clk_en        = ~gate_q;
  end
endmodule

// File: rtl/softrst_gate_chk.sv
module softrst_gate_chk #(
  parameter int DATA_W      = 32,
  parameter int SRST_POS    = 31,
  parameter int GATE_POS    = 30,
  parameter int HOLD_CYCLES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] ctrl_rd,
  input logic              blk_rst_n,
  input logic              blk_clk_en
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  logic [CW-1:0] srst_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     srst_age <= '0;
    else if (!ctrl_rd[SRST_POS])    srst_age <= '0;
    else if (srst_age != CW'(HOLD_CYCLES)) srst_age <= srst_age + 1'b1;
  end

  p_plain_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (ctrl_rd[SRST_POS] == $past(wr_data[SRST_POS])));

  p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1 && wr_data[SRST_POS]) |=> ctrl_rd[SRST_POS]);

  p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && wr_data[SRST_POS]) |=> !ctrl_rd[SRST_POS]);

  p_rsvd_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> $stable(ctrl_rd[SRST_POS]));

  p_gate_by_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[SRST_POS] && !ctrl_rd[GATE_POS]) |-> (srst_age < CW'(HOLD_CYCLES)));

  p_gate_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[SRST_POS] && ctrl_rd[GATE_POS]) |=> ctrl_rd[GATE_POS]);

  p_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rd[GATE_POS]) |-> (!blk_clk_en && !blk_rst_n == ctrl_rd[SRST_POS]));
endmodule

bind softrst_gate_ctl softrst_gate_chk #(
  .DATA_W      (DATA_W),
  .SRST_POS    (SRST_POS),
  .GATE_POS    (GATE_POS),
  .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .ctrl_rd    (ctrl_rd),
  .blk_rst_n  (blk_rst_n),
  .blk_clk_en (blk_clk_en)
);

// File: tb/tb_softrst_gate_ctl.sv
module tb_softrst_gate_ctl;
  localparam int DW   = 8;
  localparam int SP   = 7;
  localparam int GP   = 6;
  localparam int HOLD = 3;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_sel;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] ctrl_rd;
  logic          blk_rst_n;
  logic          blk_clk_en;

  int n_vec;
  int n_bad;
  bit done;

  softrst_gate_ctl #(
    .DATA_W(DW), .SRST_POS(SP), .GATE_POS(GP), .HOLD_CYCLES(HOLD), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .blk_rst_n(blk_rst_n), .blk_clk_en(blk_clk_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_state(input string tag, input bit s, input bit g);
    logic [DW-1:0] exp_rd;
    exp_rd = '0;
    exp_rd[SP] = s;
    exp_rd[GP] = g;
    n_vec++;
    if (ctrl_rd !== exp_rd || blk_rst_n !== !s || blk_clk_en !== !g) begin
      n_bad++;
      $display("FAIL %s: rd=%h rst_n=%b clk_en=%b expected rd=%h rst_n=%b clk_en=%b",
               tag, ctrl_rd, blk_rst_n, blk_clk_en, exp_rd, !s, !g);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    wr_en  = 1'b0;
    wr_sel = 2'd0;
    wr_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [DW-1:0] d);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  function automatic logic [DW-1:0] fbits(input bit s, input bit g);
    logic [DW-1:0] v;
    v = '0;
    v[SP] = s;
    v[GP] = g;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b1;
    wr_en = 1'b0;
    wr_sel = 2'd0;
    wr_data = '0;

    // R1: reset state
    hw_reset();
    check_state("R1 reset", 1'b0, 1'b0);

    // Sweep: start state x selector x every data value (R2 R3 R4 R5 R8 R9)
    for (int st = 0; st < 4; st++) begin
      for (int sel = 0; sel < 4; sel++) begin
        for (int d = 0; d < 256; d++) begin
          bit s0, g0, ds, dg, s1, gsw, g1;
          string tag;
          s0 = st[1];
          g0 = st[0];
          hw_reset();
          if (s0 && g0) begin
            do_write(2'd1, fbits(1'b1, 1'b0));
            repeat (HOLD) @(negedge clk);
          end else if (s0) begin
            do_write(2'd1, fbits(1'b1, 1'b0));
          end else if (g0) begin
            do_write(2'd1, fbits(1'b0, 1'b1));
          end
          ds = d[SP];
          dg = d[GP];
          case (sel)
            0: begin s1 = ds;        gsw = dg;        tag = "R2 plain"; end
            1: begin s1 = s0 | ds;   gsw = g0 | dg;   tag = "R3 set"; end
            2: begin s1 = s0 & ~ds;  gsw = g0 & ~dg;  tag = "R4 clear"; end
            default: begin s1 = s0;  gsw = g0;        tag = "R5 reserved"; end
          endcase
          g1 = s0 ? (g0 | gsw) : gsw;
          if (s0 && g0 && !gsw) tag = {tag, " R9 held gate"};
          do_write(2'(sel), DW'(d));
          check_state({tag, " R6 R8"}, s1, g1);
        end
      end
    end

    // R7 / R6: exact timing of the automatic gate
    hw_reset();
    do_write(2'd1, fbits(1'b1, 1'b0));
    for (int k = 0; k < HOLD; k++) begin
      check_state("R7 before hold R6", 1'b1, 1'b0);
      @(negedge clk);
    end
    check_state("R7 gate set after hold", 1'b1, 1'b1);

    // R9: clear of gate while soft reset set is ignored
    do_write(2'd2, fbits(1'b0, 1'b1));
    check_state("R9 clear ignored", 1'b1, 1'b1);
    do_write(2'd0, fbits(1'b1, 1'b0));
    check_state("R9 plain clear ignored", 1'b1, 1'b1);

    // R10: release sequence
    do_write(2'd2, fbits(1'b1, 1'b0));
    check_state("R10 reset released", 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    check_state("R10 gate stays parked", 1'b0, 1'b1);
    do_write(2'd2, fbits(1'b0, 1'b1));
    check_state("R10 ungated", 1'b0, 1'b0);
    repeat (HOLD + 2) @(negedge clk);
    check_state("R10 stays ungated", 1'b0, 1'b0);

    // R7: soft reset dropped before the hold ends, no gate
    do_write(2'd1, fbits(1'b1, 1'b0));
    do_write(2'd2, fbits(1'b1, 1'b0));
    repeat (HOLD + 2) @(negedge clk);
    check_state("R7 aborted hold", 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule